// File: doc/BRIEF.md
# Pixel Matrix Phase Sequencer and Hit Word Serializer

This block runs the periphery of a sparsified pixel matrix across a beam train. It moves through four phases. In idle nothing happens. In warm-up the analog front end is powered and allowed to settle. In detection the shared time stamp counter runs. In readout the analog section is powered down and the token scan of the matrix is started. A train-start strobe arms the sequence. The analog enable rises at once, and a programmable number of cycles later detection begins, with the counter cleared. A train-end strobe closes detection, freezes the counter, drops the analog enable and injects the first token into the matrix.

During readout, each time the token stops on a hit pixel, the matrix raises a request and presents the pixel's column and row codes. The block picks that column's 5-bit time stamp from the packed per-column buffers, packs a 13-bit word and acknowledges the request. It then shifts the word out MSB first, one bit per readout-clock tick. A frame marker flags the first bit. When the matrix reports that the token has left the last cell, and the last word has gone out, the block returns to idle. A larger matrix needs only wider code fields and a longer serializer word, which the parameters provide.

Top module: `hitword_seq`

## Requirements
- R1: After reset `analog_en`, `tok_inject`, `ser_out`, `frame_valid` and `hit_ack` are 0 and `ts_count` is 0.
- R2: A `train_start` pulse in idle raises `analog_en` in the next cycle. With `warmup` = W, `ts_count` still reads 0 at the sample W+1 cycles after the strobe edge and reads 1 one cycle later.
- R3: `ts_count` is cleared by an accepted `train_start`. It advances by one per clock only during detection, wraps from 31 to 0, and holds its value in every other phase.
- R4: A `train_end` pulse during detection lowers `analog_en` and raises `tok_inject` for exactly one cycle. `ts_count` is advanced on that edge and then held.
- R5: A hit request is accepted only in readout and only while the serializer is empty. `hit_ack` is a one-cycle pulse in the cycle after acceptance. A request held during detection or during a shift gets no acknowledge.
- R6: The word is {X[3:0], Y[3:0], TS[4:0]}, where TS is `col_ts[X*5+4 : X*5]`. It is sent MSB first, one bit per `rd_tick` cycle, and `ser_out` shows the bit in the cycle after the tick.
- R7: `frame_valid` is high for exactly one cycle, the cycle in which bit 12 of a word first appears on `ser_out`.
- R8: Readout ends only when `tok_done` has been seen and the last bit has been shifted. A `train_start` before then is ignored, and `analog_en` stays 0.
- R9: A `train_end` outside detection has no effect: no token is injected and `analog_en` does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Cell clock |
| rst_n | input | 1 | Synchronous active-low reset |
| train_start | input | 1 | Train-start strobe |
| train_end | input | 1 | Train-end strobe |
| warmup | input | 8 | Extra warm-up cycles before detection |
| tok_done | input | 1 | Token has left the last cell |
| hit_req | input | 1 | Token stopped on a hit pixel |
| hit_x | input | 4 | Column code of the hit pixel |
| hit_y | input | 4 | Row code of the hit pixel |
| col_ts | input | 80 | Packed per-column time stamps, column c in bits c*5+4:c*5 |
| rd_tick | input | 1 | Readout-clock enable, one bit per tick |
| ser_out | output | 1 | Serial hit data |
| frame_valid | output | 1 | Marks the first bit of a word |
| hit_ack | output | 1 | Hit word captured |
| tok_inject | output | 1 | First-token pulse |
| ts_count | output | 5 | Global time stamp counter |
| analog_en | output | 1 | Analog section power enable |

## Verification
The hardest case to reach is a request that arrives while a word is still being shifted, because the acknowledge must wait exactly until the last bit has gone out. The bench keeps the second request raised through all thirteen ticks of the first word and checks that the acknowledge appears only after the shift is done. A second hard case is the end of readout with a word still in flight. The bench reports token-done right after a capture, tries to start a new train in the middle of the shift, and shows that this attempt is refused while a later one is accepted.

// File: rtl/hitword_pkg.sv
// Shared types for the hit word sequencer.
// Assumes: nothing beyond the IEEE 1800-2017 language.
package hitword_pkg;

    // Phase of the beam-synchronous sequence
    typedef enum logic [1:0] {
        PH_IDLE    = 2'd0,
        PH_WARM    = 2'd1,
        PH_DETECT  = 2'd2,
        PH_READOUT = 2'd3
    } phase_t;

endpackage

// File: rtl/hitword_phase.sv
// Phase sequencer: idle -> warm-up -> detection -> readout -> idle.
// Drives the analog enable and the first-token pulse.
// Assumes: train strobes are synchronous to clk, and ser_empty/capture
// come from the serializer in the same cycle.
module hitword_phase
    import hitword_pkg::*;
#(
    parameter int WARM_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              train_start,
    input  logic              train_end,
    input  logic              tok_done,
    input  logic [WARM_W-1:0] warmup,
    input  logic              ser_empty,
    input  logic              capture,
    output phase_t            phase,
    output logic              analog_en,
    output logic              tok_inject
);

    logic [WARM_W-1:0] warm_cnt;
    logic              tok_seen;
    logic              tok_any;

    // token reported now or in an earlier readout cycle
    assign tok_any = tok_seen | tok_done;

    // phase register, warm-up countdown and phase-owned outputs
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase      <= PH_IDLE;
            warm_cnt   <= '0;
            analog_en  <= 1'b0;
            tok_inject <= 1'b0;
            tok_seen   <= 1'b0;
        end else begin
            tok_inject <= 1'b0;
            case (phase)
                PH_IDLE: begin
                    if (train_start) begin
                        phase     <= PH_WARM;
                        warm_cnt  <= warmup;
                        analog_en <= 1'b1;
                    end
                end
                PH_WARM: begin
                    if (warm_cnt == '0) begin
                        phase <= PH_DETECT;
                    end else begin
                        warm_cnt <= warm_cnt - 1'b1;
                    end
                end
                PH_DETECT: begin
                    if (train_end) begin
                        phase      <= PH_READOUT;
                        analog_en  <= 1'b0;
                        tok_inject <= 1'b1;
                        tok_seen   <= 1'b0;
                    end
                end
                PH_READOUT: begin
                    if (tok_done) begin
                        tok_seen <= 1'b1;
                    end
                    if (tok_any && ser_empty && !capture) begin
                        phase <= PH_IDLE;
                    end
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/hitword_tsgen.sv
// Global time stamp counter: clears on an accepted train start,
// counts modulo 2**TS_W while enabled, otherwise holds.
// Assumes: clear and count_en are never high together.
module hitword_tsgen #(
    parameter int TS_W = 5
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            clear,
    input  logic            count_en,
    output logic [TS_W-1:0] ts_count
);

    // counter update with natural wrap
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ts_count <= '0;
        end else if (clear) begin
            ts_count <= '0;
        end else if (count_en) begin
            ts_count <= ts_count + 1'b1;
        end
    end

endmodule

// File: rtl/hitword_ser.sv
// Hit word capture and serializer. Selects the hit column's time stamp,
// packs {X, Y, TS} and shifts it MSB first on readout ticks.
// Assumes: the matrix drops hit_req once it has seen hit_ack.
module hitword_ser #(
    parameter int X_W  = 4,
    parameter int Y_W  = 4,
    parameter int TS_W = 5,
    localparam int NCOL   = 1 << X_W,
    localparam int WORD_W = X_W + Y_W + TS_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rd_phase,
    input  logic                 hit_req,
    input  logic [X_W-1:0]       hit_x,
    input  logic [Y_W-1:0]       hit_y,
    input  logic [NCOL*TS_W-1:0] col_ts,
    input  logic                 rd_tick,
    output logic                 ser_out,
    output logic                 frame_valid,
    output logic                 hit_ack,
    output logic                 ser_empty,
    output logic                 capture
);

    localparam int CNT_W = $clog2(WORD_W + 1);

    logic [TS_W-1:0]   ts_slot [NCOL];
    logic [WORD_W-1:0] shreg;
    logic [CNT_W-1:0]  bits_left;
    logic              first_pend;

    // unpack one time stamp buffer per column
    for (genvar c = 0; c < NCOL; c++) begin : g_col
        assign ts_slot[c] = col_ts[c*TS_W +: TS_W];
    end

    // serializer state and capture condition
    assign ser_empty = (bits_left == '0);
    assign capture   = rd_phase && hit_req && ser_empty && !hit_ack;

    // load on capture, shift one bit per readout tick
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg       <= '0;
            bits_left   <= '0;
            first_pend  <= 1'b0;
            ser_out     <= 1'b0;
            frame_valid <= 1'b0;
            hit_ack     <= 1'b0;
        end else begin
            hit_ack     <= capture;
            frame_valid <= 1'b0;
            if (capture) begin
                shreg      <= {hit_x, hit_y, ts_slot[hit_x]};
                bits_left  <= CNT_W'(WORD_W);
                first_pend <= 1'b1;
            end else if (rd_tick && !ser_empty) begin
                ser_out     <= shreg[WORD_W-1];
                shreg       <= shreg << 1;
                bits_left   <= bits_left - 1'b1;
                frame_valid <= first_pend;
                first_pend  <= 1'b0;
            end
        end
    end

endmodule

// File: rtl/hitword_seq.sv
// Top: ties the phase sequencer, time stamp counter and serializer.
// Assumes: all inputs synchronous to clk; rd_tick is a one-cycle
// enable derived from the readout clock.
module hitword_seq
    import hitword_pkg::*;
#(
    parameter int X_W    = 4,
    parameter int Y_W    = 4,
    parameter int TS_W   = 5,
    parameter int WARM_W = 8,
    localparam int NCOL  = 1 << X_W
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 train_start,
    input  logic                 train_end,
    input  logic [WARM_W-1:0]    warmup,
    input  logic                 tok_done,
    input  logic                 hit_req,
    input  logic [X_W-1:0]       hit_x,
    input  logic [Y_W-1:0]       hit_y,
    input  logic [NCOL*TS_W-1:0] col_ts,
    input  logic                 rd_tick,
    output logic                 ser_out,
    output logic                 frame_valid,
    output logic                 hit_ack,
    output logic                 tok_inject,
    output logic [TS_W-1:0]      ts_count,
    output logic                 analog_en
);

    phase_t phase;
    logic   ser_empty;
    logic   capture;
    logic   ts_clear;
    logic   ts_run;
    logic   rd_phase;

    // phase decodes shared by the counter and serializer
    assign ts_clear = (phase == PH_IDLE) && train_start;
    assign ts_run   = (phase == PH_DETECT);
    assign rd_phase = (phase == PH_READOUT);

    hitword_phase #(.WARM_W(WARM_W)) u_phase (
        .clk        (clk),
        .rst_n      (rst_n),
        .train_start(train_start),
        .train_end  (train_end),
        .tok_done   (tok_done),
        .warmup     (warmup),
        .ser_empty  (ser_empty),
        .capture    (capture),
        .phase      (phase),
        .analog_en  (analog_en),
        .tok_inject (tok_inject)
    );

    hitword_tsgen #(.TS_W(TS_W)) u_ts (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear   (ts_clear),
        .count_en(ts_run),
        .ts_count(ts_count)
    );

    hitword_ser #(.X_W(X_W), .Y_W(Y_W), .TS_W(TS_W)) u_ser (
        .clk        (clk),
        .rst_n      (rst_n),
        .rd_phase   (rd_phase),
        .hit_req    (hit_req),
        .hit_x      (hit_x),
        .hit_y      (hit_y),
        .col_ts     (col_ts),
        .rd_tick    (rd_tick),
        .ser_out    (ser_out),
        .frame_valid(frame_valid),
        .hit_ack    (hit_ack),
        .ser_empty  (ser_empty),
        .capture    (capture)
    );

endmodule

// File: rtl/hitword_seq_chk.sv
// Property checker for hitword_seq, attached with bind.
// Assumes: synchronous active-low reset on rst_n.
module hitword_seq_chk #(
    parameter int TS_W = 5
) (
    input logic            clk,
    input logic            rst_n,
    input logic            train_start,
    input logic            hit_req,
    input logic            hit_ack,
    input logic            frame_valid,
    input logic            tok_inject,
    input logic            analog_en,
    input logic [TS_W-1:0] ts_count
);

    AST_TOK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        tok_inject |=> !tok_inject);                               // R4
    AST_TOK_AEN_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        tok_inject |-> !analog_en);                                // R4
    AST_TS_HOLD_UNPOWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (!analog_en && !train_start) |=> $stable(ts_count));       // R3
    AST_TS_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (ts_count == {TS_W{1'b1}}) |=> (ts_count == {TS_W{1'b1}} || ts_count == '0)); // R3
    AST_ACK_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ack |=> !hit_ack);                                     // R5
    AST_ACK_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        hit_ack |-> $past(hit_req));                               // R5
    AST_FRAME_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
        frame_valid |=> !frame_valid);                             // R7

endmodule

bind hitword_seq hitword_seq_chk #(.TS_W(TS_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .train_start(train_start),
    .hit_req    (hit_req),
    .hit_ack    (hit_ack),
    .frame_valid(frame_valid),
    .tok_inject (tok_inject),
    .analog_en  (analog_en),
    .ts_count   (ts_count)
);

// File: tb/hitword_seq_tb.sv
// Self-checking bench for hitword_seq: a table of hit words, then
// directed phase and corner-case tests.
module hitword_seq_tb;

    localparam int X_W = 4, Y_W = 4, TS_W = 5, WARM_W = 8, NCOL = 16;

    // {x, y, expected 13-bit word} with col_ts[c] = (7c+3) mod 32
    localparam logic [20:0] WORDS [5] = '{
        {4'd0,  4'd0,  13'h0003},
        {4'd15, 4'd15, 13'h1FEC},
        {4'd5,  4'd10, 13'h0B46},
        {4'd10, 4'd5,  13'h14A9},
        {4'd1,  4'd14, 13'h03CA}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic train_start = 1'b0, train_end = 1'b0, tok_done = 1'b0;
    logic [WARM_W-1:0] warmup = '0;
    logic hit_req = 1'b0;
    logic [X_W-1:0] hit_x = '0;
    logic [Y_W-1:0] hit_y = '0;
    logic [NCOL*TS_W-1:0] col_ts = '0;
    logic rd_tick = 1'b0;
    logic ser_out, frame_valid, hit_ack, tok_inject, analog_en;
    logic [TS_W-1:0] ts_count;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;
    logic [12:0] acc;
    int bit_idx;
    bit ack_seen;

    always #2 clk = ~clk;

    hitword_seq u_dut (
        .clk(clk), .rst_n(rst_n), .train_start(train_start), .train_end(train_end),
        .warmup(warmup), .tok_done(tok_done), .hit_req(hit_req), .hit_x(hit_x),
        .hit_y(hit_y), .col_ts(col_ts), .rd_tick(rd_tick), .ser_out(ser_out),
        .frame_valid(frame_valid), .hit_ack(hit_ack), .tok_inject(tok_inject),
        .ts_count(ts_count), .analog_en(analog_en)
    );

    // compare one observed value against its expected value
    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic pulse_start();
        train_start = 1'b1; @(negedge clk); train_start = 1'b0;
    endtask

    task automatic pulse_end();
        train_end = 1'b1; @(negedge clk); train_end = 1'b0;
    endtask

    task automatic pulse_tok();
        tok_done = 1'b1; @(negedge clk); tok_done = 1'b0;
    endtask

    // raise a request and wait for its acknowledge (R5)
    task automatic offer_hit(input logic [3:0] x, input logic [3:0] y);
        bit got = 1'b0;
        hit_x = x; hit_y = y; hit_req = 1'b1;
        for (int i = 0; i < 30; i++) begin
            if (hit_ack) begin got = 1'b1; break; end
            @(negedge clk);
        end
        hit_req = 1'b0;
        check("R5 ack", got, 1);
        acc = '0; bit_idx = 0; ack_seen = 1'b0;
    endtask

    // shift n bits with a gap cycle after each tick (R6, R7)
    task automatic shift_bits(input int n);
        for (int i = 0; i < n; i++) begin
            rd_tick = 1'b1;
            @(negedge clk);
            rd_tick = 1'b0;
            acc = {acc[11:0], ser_out};
            check("R7 frame_valid", frame_valid, (bit_idx == 0) ? 1 : 0);
            if (hit_ack) ack_seen = 1'b1;
            bit_idx++;
            @(negedge clk);
        end
    endtask

    initial begin
        for (int c = 0; c < NCOL; c++) col_ts[c*TS_W +: TS_W] = TS_W'((c * 7 + 3) % 32);
        step(3);
        // R1: reset state
        check("R1 analog_en", analog_en, 0);
        check("R1 tok_inject", tok_inject, 0);
        check("R1 ser_out", ser_out, 0);
        check("R1 frame_valid", frame_valid, 0);
        check("R1 hit_ack", hit_ack, 0);
        check("R1 ts_count", ts_count, 0);
        rst_n = 1'b1;
        step(2);

        // R2: warm-up of 3 extra cycles
        warmup = 8'd3;
        pulse_start();                      // sample s=0
        check("R2 analog_en rise", analog_en, 1);
        step(4);                            // s=4
        check("R2 ts before detect", ts_count, 0);
        step(1);                            // s=5
        check("R2 ts first step", ts_count, 1);
        // R5: request during detection is not acknowledged
        hit_x = 4'd2; hit_y = 4'd2; hit_req = 1'b1;
        for (int i = 0; i < 3; i++) begin
            step(1);
            check("R5 no ack in detect", hit_ack, 0);
        end
        hit_req = 1'b0;
        step(32);                           // s=40
        check("R3 wrap", ts_count, 4);

        // R4: train end
        pulse_end();
        check("R4 analog_en low", analog_en, 0);
        check("R4 tok_inject", tok_inject, 1);
        check("R4 ts frozen", ts_count, 5);
        step(1);
        check("R4 tok one cycle", tok_inject, 0);
        check("R3 ts hold", ts_count, 5);

        // R8: train start ignored in readout
        pulse_start();
        check("R8 start ignored", analog_en, 0);
        check("R8 ts unchanged", ts_count, 5);

        // R6: table of hit words
        foreach (WORDS[k]) begin
            offer_hit(WORDS[k][20:17], WORDS[k][16:13]);
            shift_bits(13);
            check("R6 word", acc, WORDS[k][12:0]);
        end

        // R5: second request held while a word is shifting
        offer_hit(4'd3, 4'd9);
        hit_x = 4'd12; hit_y = 4'd2; hit_req = 1'b1;
        shift_bits(13);
        check("R6 word busy A", acc, 13'h0738);
        check("R5 no ack while busy", ack_seen, 0);
        offer_hit(4'd12, 4'd2);
        shift_bits(13);
        check("R6 word busy B", acc, 13'h1857);

        // end of readout, then R9: train end in idle
        pulse_tok();
        step(1);
        pulse_end();
        check("R9 no token", tok_inject, 0);
        check("R9 analog_en", analog_en, 0);
        step(1);
        check("R9 no token later", tok_inject, 0);

        // R2/R3: zero warm-up, counter cleared on start
        warmup = 8'd0;
        pulse_start();                      // s=0
        check("R3 ts cleared", ts_count, 0);
        check("R2 analog_en rise W0", analog_en, 1);
        step(1);
        check("R2 ts W0 s1", ts_count, 0);
        step(1);
        check("R2 ts W0 s2", ts_count, 1);

        // R8: token done with a word still in flight
        step(3);
        pulse_end();
        step(1);
        offer_hit(4'd7, 4'd7);
        pulse_tok();
        shift_bits(6);
        pulse_start();
        check("R8 start refused mid-word", analog_en, 0);
        shift_bits(7);
        check("R6 word last", acc, 13'h0EF4);
        step(2);
        pulse_start();
        check("R8 start accepted after end", analog_en, 1);

        step(2);
        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    // watchdog: a hung run counts as a failed check
    initial begin
        for (int i = 0; i < 100000; i++) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

endmodule